// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block observes the decoded command bus of a single-rank SDR SDRAM with a parameterised number of banks (four by default). From the stream of commands it rebuilds the state of every bank and of the device as a whole. It raises a one-cycle error pulse, with a 3-bit code, whenever a command is issued that the current state forbids. It sits beside a memory controller as a protocol watchdog. It drives nothing on the memory bus and never alters the command stream.

Each bank runs its own state machine with four states: IDLE, ACTIVE, PRECHARGING and AUTO_PRECHARGING. Its transitions are:
- IDLE to ACTIVE on an activate.
- ACTIVE to PRECHARGING on a single-bank precharge.
- ACTIVE to AUTO_PRECHARGING on a read or write with auto precharge.
- ACTIVE to IDLE on a precharge-all.
- PRECHARGING or AUTO_PRECHARGING back to IDLE once the precharge window expires.

A device-wide state machine has four states: NORMAL, REFRESHING, MODE_ACCESS and PRECHARGING_ALL. It moves out of NORMAL on an accepted auto refresh, mode register load or precharge-all. It returns to NORMAL when the matching window expires. A small burst tracker remembers whether the most recent read or write burst can still be terminated.

All windows count from the clock edge that registers the command. A command registered at edge k with a window of T cycles is still inside the window at edge k+T-1. It is outside the window at edge k+T. Every window parameter must be at least 2. An illegal command is reported and otherwise ignored: it changes no state.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: `cmd_i` encodes NOP=0, INHIBIT=1, ACTIVATE=2, READ=3, READ_AP=4, WRITE=5, WRITE_AP=6, PRECHARGE=7, PRECHARGE_ALL=8, AUTO_REFRESH=9, LOAD_MODE=10, BURST_STOP=11. Codes 12 to 15 are undefined and report error code 7. That check takes priority over every other rule.
- R2: After reset every bank is IDLE, `all_idle_o` is 1 and `err_o` is 0.
- R3: The 2-bit state of bank b sits at `bank_state_o[2b+1:2b]`, encoded IDLE=0, ACTIVE=1, PRECHARGING=2, AUTO_PRECHARGING=3. ACTIVATE moves an IDLE bank to ACTIVE. ACTIVATE to a bank that is not IDLE reports code 3.
- R4: READ, READ_AP, WRITE and WRITE_AP are legal only when the addressed bank is ACTIVE, whatever their auto-precharge flag. Otherwise they report code 4.
- R5: PRECHARGE is legal to an IDLE bank, which it leaves IDLE, and to an ACTIVE bank, which it makes PRECHARGING for T_RP cycles before the bank returns to IDLE. PRECHARGE to a bank in PRECHARGING or AUTO_PRECHARGING reports code 5. PRECHARGE_ALL while any bank is in either of those states also reports code 5.
- R6: READ_AP or WRITE_AP to an ACTIVE bank makes it AUTO_PRECHARGING for T_RP cycles, after which it is IDLE.
- R7: AUTO_REFRESH and LOAD_MODE are legal only when every bank is IDLE. Otherwise they report code 2.
- R8: An accepted AUTO_REFRESH, LOAD_MODE or PRECHARGE_ALL opens a device window of T_RC, T_MRD or T_RP cycles respectively. PRECHARGE_ALL also makes every bank IDLE. During the window `all_idle_o` is 0, and any command other than NOP or INHIBIT reports code 1.
- R9: BURST_STOP ignores `bank_i`. It is legal only while the most recent READ or WRITE without auto precharge is still open. A burst stays open until a BURST_STOP, a later auto-precharge read or write, a PRECHARGE to its bank, or a PRECHARGE_ALL. Otherwise BURST_STOP reports code 6. It never changes any bank state.
- R10: `err_o` and `err_code_o` are registered. They are valid for the cycle after the edge that registers the command, and `err_code_o` is 0 whenever `err_o` is 0. An illegal command changes no bank or device state.
- R11: A command addressed to one bank leaves every other bank's state unchanged.
- R12: `all_idle_o` is 1 exactly when the device machine is NORMAL and every bank is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 4 | Decoded command code (encoding in R1) |
| bank_i | input | $clog2(NUM_BANKS) | Bank address of the command |
| bank_state_o | output | 2*NUM_BANKS | Packed per-bank state, 2 bits per bank |
| all_idle_o | output | 1 | Device NORMAL and all banks IDLE |
| err_o | output | 1 | One-cycle pulse for an illegal command |
| err_code_o | output | 3 | Rule violated: 1 busy window, 2 banks not idle, 3 activate on non-idle bank, 4 access to inactive bank, 5 precharge during precharge, 6 no open burst, 7 undefined code |

## Verification
The bench builds the monitor with four banks, T_RP=3, T_RC=5 and T_MRD=2. These short windows put both the last busy edge and the first free edge of every window, per bank and device-wide, within a few dozen cycles of stimulus. T_MRD=2 exercises the shortest window the counters allow. With four banks, the bench can show that a bank address on BURST_STOP is ignored and that a precharge to one bank leaves a neighbour's state intact.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP     = 4'd0,
        CMD_INHIBIT = 4'd1,
        CMD_ACT     = 4'd2,
        CMD_RD      = 4'd3,
        CMD_RDA     = 4'd4,
        CMD_WR      = 4'd5,
        CMD_WRA     = 4'd6,
        CMD_PRE     = 4'd7,
        CMD_PREA    = 4'd8,
        CMD_REF     = 4'd9,
        CMD_LMR     = 4'd10,
        CMD_BST     = 4'd11
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_ACTIVE  = 2'd1,
        BK_PRECH   = 2'd2,
        BK_AUTOPRE = 2'd3
    } bank_st_e;

    typedef enum logic [1:0] {
        DV_NORMAL  = 2'd0,
        DV_REFRESH = 2'd1,
        DV_MODEREG = 2'd2,
        DV_PREALL  = 2'd3
    } dev_st_e;

    typedef enum logic [2:0] {
        ERR_NONE        = 3'd0,
        ERR_DEV_BUSY    = 3'd1,
        ERR_NEED_IDLE   = 3'd2,
        ERR_ACT_BUSY    = 3'd3,
        ERR_RW_INACTIVE = 3'd4,
        ERR_PRE_TRANS   = 3'd5,
        ERR_NO_BURST    = 3'd6,
        ERR_UNDEF       = 3'd7
    } err_e;

endpackage

// File: rtl/sdram_mon_bank.sv
module sdram_mon_bank
    import sdram_mon_pkg::*;
#(
    parameter int T_RP = 3,
    parameter int CW   = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     open_i,
    input  logic     close_i,
    input  logic     close_ap_i,
    input  logic     flush_i,
    output bank_st_e state_o
);

    localparam logic [CW-1:0] LOAD = CW'(T_RP - 1);
    localparam logic [CW-1:0] LAST = CW'(1);

    bank_st_e        state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BK_IDLE: begin
                if (open_i) state_d = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (flush_i) begin
                    state_d = BK_IDLE;
                end else if (close_i) begin
                    state_d = BK_PRECH;
                    cnt_d   = LOAD;
                end else if (close_ap_i) begin
                    state_d = BK_AUTOPRE;
                    cnt_d   = LOAD;
                end
            end
            BK_PRECH, BK_AUTOPRE: begin
                if (cnt_q <= LAST) begin
                    state_d = BK_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - LAST;
                end
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
    end

endmodule

// File: rtl/sdram_mon_device.sv
module sdram_mon_device
    import sdram_mon_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RC  = 8,
    parameter int T_MRD = 2,
    parameter int CW    = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_ref_i,
    input  logic    start_mrs_i,
    input  logic    start_pall_i,
    output dev_st_e state_o
);

    localparam logic [CW-1:0] LOAD_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] LOAD_MRD = CW'(T_MRD - 1);
    localparam logic [CW-1:0] LOAD_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] LAST     = CW'(1);

    dev_st_e         state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DV_NORMAL: begin
                if (start_ref_i) begin
                    state_d = DV_REFRESH;
                    cnt_d   = LOAD_RC;
                end else if (start_mrs_i) begin
                    state_d = DV_MODEREG;
                    cnt_d   = LOAD_MRD;
                end else if (start_pall_i) begin
                    state_d = DV_PREALL;
                    cnt_d   = LOAD_RP;
                end
            end
            DV_REFRESH, DV_MODEREG, DV_PREALL: begin
                if (cnt_q <= LAST) begin
                    state_d = DV_NORMAL;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - LAST;
                end
            end
            default: state_d = DV_NORMAL;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DV_NORMAL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
    end

endmodule

// File: rtl/sdram_mon_rules.sv
module sdram_mon_rules
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input  logic [3:0]           cmd_i,
    input  logic [BA_W-1:0]      bank_i,
    input  bank_st_e             bank_st_i [NUM_BANKS],
    input  dev_st_e              dev_st_i,
    input  logic                 burst_live_i,
    input  logic [BA_W-1:0]      burst_bank_i,
    output err_e                 code_o,
    output logic [NUM_BANKS-1:0] open_o,
    output logic [NUM_BANKS-1:0] close_o,
    output logic [NUM_BANKS-1:0] close_ap_o,
    output logic                 flush_o,
    output logic                 start_ref_o,
    output logic                 start_mrs_o,
    output logic                 start_pall_o,
    output logic                 burst_set_o,
    output logic                 burst_clr_o
);

    logic [NUM_BANKS-1:0] bank_oh;
    logic                 banks_idle;
    logic                 any_trans;
    logic                 nopish;
    bank_st_e             sel_st;

    always_comb begin
        bank_oh    = '0;
        banks_idle = 1'b1;
        any_trans  = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_i == BA_W'(b)) bank_oh[b] = 1'b1;
            if (bank_st_i[b] != BK_IDLE) banks_idle = 1'b0;
            if (bank_st_i[b] == BK_PRECH || bank_st_i[b] == BK_AUTOPRE) any_trans = 1'b1;
        end
        sel_st = bank_st_i[bank_i];
        nopish = (cmd_i == CMD_NOP) || (cmd_i == CMD_INHIBIT);
    end

    always_comb begin
        code_o       = ERR_NONE;
        open_o       = '0;
        close_o      = '0;
        close_ap_o   = '0;
        flush_o      = 1'b0;
        start_ref_o  = 1'b0;
        start_mrs_o  = 1'b0;
        start_pall_o = 1'b0;
        burst_set_o  = 1'b0;
        burst_clr_o  = 1'b0;
        if (cmd_i > CMD_BST) begin
            code_o = ERR_UNDEF;
        end else if (dev_st_i != DV_NORMAL && !nopish) begin
            code_o = ERR_DEV_BUSY;
        end else begin
            unique case (cmd_e'(cmd_i))
                CMD_NOP, CMD_INHIBIT: begin
                end
                CMD_ACT: begin
                    if (sel_st != BK_IDLE) code_o = ERR_ACT_BUSY;
                    else                   open_o = bank_oh;
                end
                CMD_RD, CMD_WR: begin
                    if (sel_st != BK_ACTIVE) code_o = ERR_RW_INACTIVE;
                    else                     burst_set_o = 1'b1;
                end
                CMD_RDA, CMD_WRA: begin
                    if (sel_st != BK_ACTIVE) begin
                        code_o = ERR_RW_INACTIVE;
                    end else begin
                        close_ap_o  = bank_oh;
                        burst_clr_o = 1'b1;
                    end
                end
                CMD_PRE: begin
                    if (sel_st == BK_PRECH || sel_st == BK_AUTOPRE) begin
                        code_o = ERR_PRE_TRANS;
                    end else begin
                        close_o = bank_oh;
                        if (burst_live_i && burst_bank_i == bank_i) burst_clr_o = 1'b1;
                    end
                end
                CMD_PREA: begin
                    if (any_trans) begin
                        code_o = ERR_PRE_TRANS;
                    end else begin
                        flush_o      = 1'b1;
                        start_pall_o = 1'b1;
                        burst_clr_o  = 1'b1;
                    end
                end
                CMD_REF: begin
                    if (!banks_idle) code_o = ERR_NEED_IDLE;
                    else             start_ref_o = 1'b1;
                end
                CMD_LMR: begin
                    if (!banks_idle) code_o = ERR_NEED_IDLE;
                    else             start_mrs_o = 1'b1;
                end
                CMD_BST: begin
                    if (!burst_live_i) code_o = ERR_NO_BURST;
                    else               burst_clr_o = 1'b1;
                end
                default: code_o = ERR_UNDEF;
            endcase
        end
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int T_RP      = 3,
    parameter  int T_RC      = 8,
    parameter  int T_MRD     = 2,
    localparam int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             cmd_i,
    input  logic [BA_W-1:0]        bank_i,
    output logic [2*NUM_BANKS-1:0] bank_state_o,
    output logic                   all_idle_o,
    output logic                   err_o,
    output logic [2:0]             err_code_o
);

    localparam int T_MAX0 = (T_RC > T_RP) ? T_RC : T_RP;
    localparam int T_MAX  = (T_MAX0 > T_MRD) ? T_MAX0 : T_MRD;
    localparam int CW     = $clog2(T_MAX + 1);

    bank_st_e             bank_st [NUM_BANKS];
    dev_st_e              dev_st;
    err_e                 code;
    logic [NUM_BANKS-1:0] open_v, close_v, close_ap_v;
    logic                 flush, start_ref, start_mrs, start_pall;
    logic                 burst_set, burst_clr;
    logic                 burst_live_q;
    logic [BA_W-1:0]      burst_bank_q;
    logic                 err_q;
    logic [2:0]           err_code_q;

    sdram_mon_rules #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W)
    ) u_rules (
        .cmd_i        (cmd_i),
        .bank_i       (bank_i),
        .bank_st_i    (bank_st),
        .dev_st_i     (dev_st),
        .burst_live_i (burst_live_q),
        .burst_bank_i (burst_bank_q),
        .code_o       (code),
        .open_o       (open_v),
        .close_o      (close_v),
        .close_ap_o   (close_ap_v),
        .flush_o      (flush),
        .start_ref_o  (start_ref),
        .start_mrs_o  (start_mrs),
        .start_pall_o (start_pall),
        .burst_set_o  (burst_set),
        .burst_clr_o  (burst_clr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_mon_bank #(
            .T_RP (T_RP),
            .CW   (CW)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .open_i     (open_v[b]),
            .close_i    (close_v[b]),
            .close_ap_i (close_ap_v[b]),
            .flush_i    (flush),
            .state_o    (bank_st[b])
        );
    end

    sdram_mon_device #(
        .T_RP  (T_RP),
        .T_RC  (T_RC),
        .T_MRD (T_MRD),
        .CW    (CW)
    ) u_device (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_ref_i  (start_ref),
        .start_mrs_i  (start_mrs),
        .start_pall_i (start_pall),
        .state_o      (dev_st)
    );

    // burst tracker and error register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_live_q <= 1'b0;
            burst_bank_q <= '0;
            err_q        <= 1'b0;
            err_code_q   <= 3'd0;
        end else begin
            if (burst_set) begin
                burst_live_q <= 1'b1;
                burst_bank_q <= bank_i;
            end else if (burst_clr) begin
                burst_live_q <= 1'b0;
            end
            err_q      <= (code != ERR_NONE);
            err_code_q <= code;
        end
    end

    // outputs
    always_comb begin
        all_idle_o = (dev_st == DV_NORMAL);
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_state_o[2*b +: 2] = bank_st[b];
            if (bank_st[b] != BK_IDLE) all_idle_o = 1'b0;
        end
        err_o      = err_q;
        err_code_o = err_code_q;
    end

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
    import sdram_mon_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [3:0]             cmd_i,
    input logic [BA_W-1:0]        bank_i,
    input logic [2*NUM_BANKS-1:0] bank_state_o,
    input logic                   all_idle_o,
    input logic                   err_o,
    input logic [2:0]             err_code_o
);

    logic is_rw;
    always_comb begin
        is_rw = (cmd_i == CMD_RD) || (cmd_i == CMD_RDA) ||
                (cmd_i == CMD_WR) || (cmd_i == CMD_WRA);
    end

    p_undef_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i > CMD_BST) |=> (err_o && err_code_o == ERR_UNDEF));

    p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ACT && all_idle_o) |=>
        (!err_o && bank_state_o[2*int'($past(bank_i)) +: 2] == BK_ACTIVE));

    p_rw_on_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rw && all_idle_o) |=> (err_o && err_code_o == ERR_RW_INACTIVE));

    p_ref_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_REF) |=> !all_idle_o);

    p_nop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NOP || cmd_i == CMD_INHIBIT) |=> !err_o);

    p_code_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> (err_code_o == ERR_NONE));

    p_code_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (err_code_o != ERR_NONE));

    p_busy_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && err_code_o == ERR_DEV_BUSY) |-> (bank_state_o == $past(bank_state_o)));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd_i),
    .bank_i       (bank_i),
    .bank_state_o (bank_state_o),
    .all_idle_o   (all_idle_o),
    .err_o        (err_o),
    .err_code_o   (err_code_o)
);

// File: tb/sdram_cmd_monitor_tb.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb;
    import sdram_mon_pkg::*;

    localparam int NB    = 4;
    localparam int T_RP  = 3;
    localparam int T_RC  = 5;
    localparam int T_MRD = 2;
    localparam int NV    = 41;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd = CMD_NOP;
    logic [1:0] bank = 2'd0;
    logic [7:0] bst;
    logic       all_idle, err;
    logic [2:0] code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sdram_cmd_monitor #(
        .NUM_BANKS (NB),
        .T_RP      (T_RP),
        .T_RC      (T_RC),
        .T_MRD     (T_MRD)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd),
        .bank_i       (bank),
        .bank_state_o (bst),
        .all_idle_o   (all_idle),
        .err_o        (err),
        .err_code_o   (code)
    );

    // {req[3:0], cmd[3:0], bank[1:0], err, code[2:0]}
    localparam logic [13:0] VEC [NV] = '{
        {4'd10, CMD_NOP,     2'd0, 1'b0, ERR_NONE},        // 0  R10 quiet
        {4'd4,  CMD_RD,      2'd0, 1'b1, ERR_RW_INACTIVE}, // 1  R4 read idle bank
        {4'd3,  CMD_ACT,     2'd0, 1'b0, ERR_NONE},        // 2  R3
        {4'd3,  CMD_ACT,     2'd0, 1'b1, ERR_ACT_BUSY},    // 3  R3 already active
        {4'd4,  CMD_RD,      2'd0, 1'b0, ERR_NONE},        // 4  R4 burst on bank 0
        {4'd11, CMD_ACT,     2'd1, 1'b0, ERR_NONE},        // 5  R11
        {4'd4,  CMD_WR,      2'd1, 1'b0, ERR_NONE},        // 6  R4 burst on bank 1
        {4'd9,  CMD_BST,     2'd0, 1'b0, ERR_NONE},        // 7  R9 bank field ignored
        {4'd9,  CMD_BST,     2'd2, 1'b1, ERR_NO_BURST},    // 8  R9 nothing open
        {4'd7,  CMD_REF,     2'd0, 1'b1, ERR_NEED_IDLE},   // 9  R7
        {4'd5,  CMD_PRE,     2'd0, 1'b0, ERR_NONE},        // 10 R5 start tRP
        {4'd5,  CMD_PRE,     2'd0, 1'b1, ERR_PRE_TRANS},   // 11 R5
        {4'd5,  CMD_ACT,     2'd0, 1'b1, ERR_ACT_BUSY},    // 12 R5 last busy edge
        {4'd5,  CMD_ACT,     2'd0, 1'b0, ERR_NONE},        // 13 R5 first free edge
        {4'd6,  CMD_WRA,     2'd0, 1'b0, ERR_NONE},        // 14 R6
        {4'd9,  CMD_BST,     2'd0, 1'b1, ERR_NO_BURST},    // 15 R9 auto-precharge burst
        {4'd6,  CMD_RD,      2'd0, 1'b1, ERR_RW_INACTIVE}, // 16 R6
        {4'd6,  CMD_ACT,     2'd0, 1'b0, ERR_NONE},        // 17 R6 idle after tRP
        {4'd8,  CMD_PREA,    2'd0, 1'b0, ERR_NONE},        // 18 R8
        {4'd8,  CMD_NOP,     2'd0, 1'b0, ERR_NONE},        // 19 R8
        {4'd8,  CMD_ACT,     2'd2, 1'b1, ERR_DEV_BUSY},    // 20 R8 last busy edge
        {4'd8,  CMD_REF,     2'd0, 1'b0, ERR_NONE},        // 21 R8 first free edge
        {4'd8,  CMD_INHIBIT, 2'd0, 1'b0, ERR_NONE},        // 22 R8
        {4'd8,  CMD_LMR,     2'd0, 1'b1, ERR_DEV_BUSY},    // 23 R8
        {4'd8,  CMD_NOP,     2'd0, 1'b0, ERR_NONE},        // 24 R8
        {4'd8,  CMD_PRE,     2'd3, 1'b1, ERR_DEV_BUSY},    // 25 R8 last refresh edge
        {4'd8,  CMD_LMR,     2'd0, 1'b0, ERR_NONE},        // 26 R8
        {4'd8,  CMD_ACT,     2'd1, 1'b1, ERR_DEV_BUSY},    // 27 R8 tMRD
        {4'd8,  CMD_ACT,     2'd1, 1'b0, ERR_NONE},        // 28 R8
        {4'd7,  CMD_LMR,     2'd0, 1'b1, ERR_NEED_IDLE},   // 29 R7
        {4'd1,  4'd12,       2'd0, 1'b1, ERR_UNDEF},       // 30 R1
        {4'd5,  CMD_PRE,     2'd2, 1'b0, ERR_NONE},        // 31 R5 idle bank
        {4'd4,  CMD_RD,      2'd1, 1'b0, ERR_NONE},        // 32 R4
        {4'd5,  CMD_PRE,     2'd1, 1'b0, ERR_NONE},        // 33 R5
        {4'd5,  CMD_PREA,    2'd0, 1'b1, ERR_PRE_TRANS},   // 34 R5
        {4'd9,  CMD_BST,     2'd1, 1'b1, ERR_NO_BURST},    // 35 R9 closed by precharge
        {4'd3,  CMD_ACT,     2'd1, 1'b0, ERR_NONE},        // 36 R3
        {4'd6,  CMD_RDA,     2'd1, 1'b0, ERR_NONE},        // 37 R6
        {4'd10, CMD_NOP,     2'd0, 1'b0, ERR_NONE},        // 38 R10
        {4'd10, CMD_NOP,     2'd0, 1'b0, ERR_NONE},        // 39 R10
        {4'd7,  CMD_REF,     2'd0, 1'b0, ERR_NONE}         // 40 R7 all idle again
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [1:0] b);
        @(negedge clk);
        cmd  = c;
        bank = b;
        @(posedge clk);
        #1;
    endtask

    task automatic run_vec(input int i);
        logic [13:0] v;
        string tag;
        v = VEC[i];
        issue(v[9:6], v[5:4]);
        tag = $sformatf("R%0d vector %0d err", v[13:10], i);
        check(tag, int'(err), int'(v[3]));
        tag = $sformatf("R%0d vector %0d code", v[13:10], i);
        check(tag, int'(code), int'(v[2:0]));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        check("R2 bank_state after reset", int'(bst), 0);
        check("R2 all_idle after reset", int'(all_idle), 1);
        check("R2 err after reset", int'(err), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R8 / R12: refresh registered at the last table edge, window T_RC=5
        check("R8 all_idle right after refresh", int'(all_idle), 0);
        for (int k = 1; k < T_RC; k++) begin
            issue(CMD_NOP, 2'd0);
            check($sformatf("R12 all_idle at refresh edge +%0d", k), int'(all_idle), (k == T_RC - 1) ? 1 : 0);
        end

        // R3 / R11: activate bank 2 only
        issue(CMD_ACT, 2'd2);
        check("R3 R11 bank 2 active only", int'(bst), 8'h10);
        check("R12 all_idle with bank open", int'(all_idle), 0);
        // R9: no open burst, state untouched
        issue(CMD_BST, 2'd2);
        check("R9 stop with no burst code", int'(code), 6);
        check("R9 stop leaves state", int'(bst), 8'h10);
        issue(CMD_RD, 2'd2);
        issue(CMD_ACT, 2'd0);
        check("R11 bank 0 opened, bank 2 kept", int'(bst), 8'h11);
        issue(CMD_BST, 2'd3);
        check("R9 stop with other bank field legal", int'(err), 0);
        check("R9 stop keeps banks", int'(bst), 8'h11);
        // R5: precharge bank 2 for T_RP=3
        issue(CMD_PRE, 2'd2);
        check("R5 R11 bank 2 precharging", int'(bst), 8'h21);
        issue(CMD_NOP, 2'd0);
        check("R5 bank 2 still precharging", int'(bst), 8'h21);
        issue(CMD_NOP, 2'd0);
        check("R5 bank 2 idle after tRP", int'(bst), 8'h01);
        // R10: pulse lasts one cycle
        issue(CMD_RD, 2'd3);
        check("R10 pulse set", int'(err), 1);
        issue(CMD_NOP, 2'd0);
        check("R10 pulse cleared", int'(err), 0);
        check("R10 code cleared", int'(code), 0);

        // R2: reset mid-operation
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 bank_state after second reset", int'(bst), 0);
        check("R2 all_idle after second reset", int'(all_idle), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule